// File: doc/BRIEF.md
# Shared-Ramp Symmetric PWM Neuron Array

This block turns a group of digital neuron activation values into pulse-width-coded output states. One reference value per cycle is sent to every neuron at once, and each neuron compares its own held activation against it. The reference values are read from a small writable table, so the mapping from activation to pulse width can be set to any monotonic shape, such as a sigmoid at a chosen steepness.

Each evaluation window lasts exactly twice the table depth in cycles, whatever the data. In the first half the table is read from its last entry down to its first. In the second half it is read from its first entry up to its last. A neuron is high whenever its activation is at least the current reference, so each pulse is centred on the middle of the window. Its width, as a fraction of the whole window, is the neuron's output state. Software loads the table while the array is idle, presents the activations and pulses the start input. It then reads the pulse outputs and sees a one-cycle done flag at the end.

The controller walks four named states. `ST_IDLE` goes to `ST_FALL` on start. `ST_FALL` goes to `ST_RISE` after its last tick. `ST_RISE` goes to `ST_DONE` after its last tick. `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `pwm_neuron_array`

## Requirements
- R1: After reset and whenever no sweep is running, every pulse output and done_o are low.
- R2: A start_i seen at a clock edge while idle begins a window of 2*DEPTH ticks in the next cycle. done_o is high for exactly the one cycle that follows the last tick, and the array is idle the cycle after that.
- R3: In tick t, where t runs from 0 to DEPTH-1, the reference is table entry DEPTH-1-t. In tick t, where t runs from DEPTH to 2*DEPTH-1, it is entry t-DEPTH. Neuron n (activation bits act_i[n*ACT_W +: ACT_W], pulse bit pulse_o[n]) is high in a tick exactly when its activation is greater than or equal to the reference, compared as unsigned numbers.
- R4: For any table contents, the pulse of each neuron in tick t equals its pulse in tick 2*DEPTH-1-t.
- R5: With an ascending table, an activation below entry 0 gives no pulse at all. An activation at or above the last entry stays high for all 2*DEPTH ticks.
- R6: Activations are captured at the start edge. Changes on act_i during a sweep have no effect on that sweep.
- R7: start_i is ignored while a sweep or its done cycle is in progress. The window neither restarts nor stretches.
- R8: Table writes (wr_en_i, wr_addr_i, wr_data_i) are ignored unless the array is idle.
- R9: A table write made while idle changes the transfer function of every later sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one evaluation window |
| act_i | input | NUM_NEURONS*ACT_W | Packed activations, neuron n in bits n*ACT_W +: ACT_W |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | $clog2(DEPTH) | Table entry to write |
| wr_data_i | input | ACT_W | Reference value to write |
| pulse_o | output | NUM_NEURONS | Per-neuron pulse-width-coded state |
| done_o | output | 1 | One-cycle flag after the last tick |

## Verification
The bench checks every tick of each window against a reference value it computes itself. This catches a design that reads the table in the wrong order, or that compares with > instead of >=. Such designs show up as pulses that are off-centre or one tick pair short for activations equal to a table entry. Activations just below the smallest entry and at or above the largest entry test the empty and full-window limits. An off-by-one in the tick counter would change the window length or move done_o. Further directed sweeps change act_i, pulse start_i and write the table mid-sweep. A design that failed to hold its activations, restarted on start, or accepted busy writes would change a pulse width or the done timing.

// File: rtl/pwm_array_pkg.sv
package pwm_array_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FALL = 2'd1,
        ST_RISE = 2'd2,
        ST_DONE = 2'd3
    } sweep_state_e;
endpackage

// File: rtl/ramp_table.sv
module ramp_table #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [DEPTH*DATA_W-1:0] tbl_flat
);
    logic [DATA_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                entry[g] <= wr_data;
        end
        assign tbl_flat[g*DATA_W +: DATA_W] = entry[g];
    end

    assign rd_data = entry[rd_addr];
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import pwm_array_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output sweep_state_e  state_o,
    output logic [AW-1:0] cnt_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          idle_o,
    output logic          active_o,
    output logic          done_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sweep_state_e  state, state_nxt;
    logic [AW-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_FALL;
                    cnt_nxt   = '0;
                end
            end
            ST_FALL: begin
                if (cnt == LAST) begin
                    state_nxt = ST_RISE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_RISE: begin
                if (cnt == LAST) begin
                    state_nxt = ST_DONE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle_o    = 1'b0;
        active_o  = 1'b0;
        done_o    = 1'b0;
        rd_addr_o = cnt;
        unique case (state)
            ST_IDLE: idle_o = 1'b1;
            ST_FALL: begin
                active_o  = 1'b1;
                rd_addr_o = LAST - cnt;
            end
            ST_RISE: active_o = 1'b1;
            ST_DONE: done_o   = 1'b1;
            default: idle_o   = 1'b1;
        endcase
    end

    assign state_o = state;
    assign cnt_o   = cnt;
endmodule

// File: rtl/neuron_cmp.sv
module neuron_cmp #(
    parameter int ACT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACT_W-1:0] act_in,
    input  logic [ACT_W-1:0] ref_val,
    input  logic             active,
    output logic [ACT_W-1:0] act_q,
    output logic             pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (load)
            act_q <= act_in;
    end

    assign pulse = active && (act_q >= ref_val);
endmodule

// File: rtl/pwm_neuron_array.sv
module pwm_neuron_array
    import pwm_array_pkg::*;
#(
    parameter int NUM_NEURONS = 4,
    parameter int ACT_W       = 8,
    parameter int DEPTH       = 8,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [NUM_NEURONS*ACT_W-1:0] act_i,
    input  logic                         wr_en_i,
    input  logic [AW-1:0]                wr_addr_i,
    input  logic [ACT_W-1:0]             wr_data_i,
    output logic [NUM_NEURONS-1:0]       pulse_o,
    output logic                         done_o
);
    sweep_state_e                   state;
    logic [AW-1:0]                  cnt;
    logic [AW-1:0]                  rd_addr;
    logic                           idle;
    logic                           active;
    logic [ACT_W-1:0]               ref_val;
    logic [DEPTH*ACT_W-1:0]         tbl_flat;
    logic [NUM_NEURONS*ACT_W-1:0]   act_hold;

    sweep_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .state_o   (state),
        .cnt_o     (cnt),
        .rd_addr_o (rd_addr),
        .idle_o    (idle),
        .active_o  (active),
        .done_o    (done_o)
    );

    ramp_table #(.DEPTH(DEPTH), .DATA_W(ACT_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i && idle),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .rd_addr  (rd_addr),
        .rd_data  (ref_val),
        .tbl_flat (tbl_flat)
    );

    for (genvar n = 0; n < NUM_NEURONS; n++) begin : g_neuron
        neuron_cmp #(.ACT_W(ACT_W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (idle && start_i),
            .act_in  (act_i[n*ACT_W +: ACT_W]),
            .ref_val (ref_val),
            .active  (active),
            .act_q   (act_hold[n*ACT_W +: ACT_W]),
            .pulse   (pulse_o[n])
        );
    end
endmodule

// File: rtl/pwm_neuron_array_checker.sv
module pwm_neuron_array_checker
    import pwm_array_pkg::*;
#(
    parameter int NUM_NEURONS = 4,
    parameter int ACT_W       = 8,
    parameter int DEPTH       = 8,
    localparam int AW         = $clog2(DEPTH)
) (
    input logic                         clk,
    input logic                         rst_n,
    input sweep_state_e                 state,
    input logic [AW-1:0]                cnt,
    input logic [NUM_NEURONS-1:0]       pulse_o,
    input logic                         done_o,
    input logic [NUM_NEURONS*ACT_W-1:0] act_hold,
    input logic [DEPTH*ACT_W-1:0]       tbl_flat
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (pulse_o == '0 && !done_o));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RISE && cnt == LAST) |=> done_o);

    p_fall_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FALL && cnt != LAST) |=> (state == ST_FALL && cnt == $past(cnt) + 1'b1));

    p_mid_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RISE && cnt == '0) |-> (pulse_o == $past(pulse_o)));

    p_act_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(act_hold));

    p_table_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(tbl_flat));
endmodule

bind pwm_neuron_array pwm_neuron_array_checker #(
    .NUM_NEURONS(NUM_NEURONS), .ACT_W(ACT_W), .DEPTH(DEPTH)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .cnt      (cnt),
    .pulse_o  (pulse_o),
    .done_o   (done_o),
    .act_hold (act_hold),
    .tbl_flat (tbl_flat)
);

// File: tb/pwm_neuron_array_test.sv
`timescale 1ns/1ps
module pwm_neuron_array_test;
    localparam int NUM   = 4;
    localparam int AW_T  = 8;
    localparam int DEP   = 8;
    localparam int ADW   = $clog2(DEP);
    localparam int TICKS = 2 * DEP;
    localparam int NVEC  = 4;

    // stimulus activations and expected widths (ascending table 10..240)
    localparam int VEC_A [NVEC][NUM] = '{
        '{0, 9, 10, 255}, '{100, 239, 240, 20},
        '{19, 79, 80, 161}, '{200, 199, 41, 121}};
    localparam int VEC_W [NVEC][NUM] = '{
        '{0, 0, 2, 16}, '{8, 14, 16, 4},
        '{2, 6, 8, 12}, '{14, 12, 6, 10}};
    localparam int TBL_A [DEP] = '{10, 20, 40, 80, 120, 160, 200, 240};

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start_i = 1'b0;
    logic [NUM*AW_T-1:0]   act_i = '0;
    logic                  wr_en_i = 1'b0;
    logic [ADW-1:0]        wr_addr_i = '0;
    logic [AW_T-1:0]       wr_data_i = '0;
    logic [NUM-1:0]        pulse_o;
    logic                  done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int model_tbl [DEP];
    logic [NUM-1:0] got [TICKS];
    int  widths [NUM];
    bit  done_ok;

    always #2.5 clk = ~clk;

    pwm_neuron_array #(.NUM_NEURONS(NUM), .ACT_W(AW_T), .DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .act_i(act_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .pulse_o(pulse_o), .done_o(done_o));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_ref(input int t);
        return (t < DEP) ? model_tbl[DEP-1-t] : model_tbl[t-DEP];
    endfunction

    task automatic write_entry(input int addr, input int val);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = ADW'(addr); wr_data_i = AW_T'(val);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // mode: 0 plain, 1 change acts mid-sweep, 2 start mid-sweep, 3 write mid-sweep
    task automatic run_sweep(input logic [NUM*AW_T-1:0] acts, input int mode, input string req);
        logic [NUM-1:0] exp_v;
        @(negedge clk);
        act_i = acts; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        done_ok = 1'b1;
        for (int n = 0; n < NUM; n++) widths[n] = 0;
        for (int t = 0; t < TICKS; t++) begin
            got[t] = pulse_o;
            if (done_o) done_ok = 1'b0;
            for (int n = 0; n < NUM; n++) begin
                exp_v[n] = (int'(acts[n*AW_T +: AW_T]) >= model_ref(t));
                if (pulse_o[n]) widths[n]++;
            end
            // R3: per-tick compare against the mirrored-table reference
            check(pulse_o == exp_v, {req, " R3 tick pattern"}, int'(pulse_o), int'(exp_v));
            if (mode == 1 && t == 1) act_i = ~acts;
            if (mode == 2 && (t == 3 || t == DEP + 2)) start_i = 1'b1;
            if (mode == 3 && t == 2) begin
                wr_en_i = 1'b1; wr_addr_i = '0; wr_data_i = '0;
            end
            @(negedge clk);
            start_i = 1'b0; wr_en_i = 1'b0;
        end
        // R2: done exactly one cycle after the last tick
        check(done_ok && done_o && pulse_o == '0, {req, " R2 done timing"}, int'(done_o), 1);
        if (mode == 2) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o && pulse_o == '0, {req, " R2/R7 back to idle"}, int'(pulse_o), 0);
        for (int t = 0; t < DEP; t++)
            check(got[t] == got[TICKS-1-t], {req, " R4 symmetry"}, int'(got[t]), int'(got[TICKS-1-t]));
    endtask

    task automatic wait_idle_quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(pulse_o == '0 && !done_o, "R1 idle outputs", int'(pulse_o), 0);
        end
    endtask

    initial begin
        logic [NUM*AW_T-1:0] v;
        repeat (3) @(negedge clk);
        check(pulse_o == '0 && !done_o, "R1 reset state", int'({done_o, pulse_o}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < DEP; i++) begin
            write_entry(i, TBL_A[i]);
            model_tbl[i] = TBL_A[i];
        end
        wait_idle_quiet(3);

        // vector table walk (R5 limits among the vectors)
        for (int k = 0; k < NVEC; k++) begin
            for (int n = 0; n < NUM; n++) v[n*AW_T +: AW_T] = AW_T'(VEC_A[k][n]);
            run_sweep(v, 0, "vec");
            for (int n = 0; n < NUM; n++)
                check(widths[n] == VEC_W[k][n], "R5 pulse width", widths[n], VEC_W[k][n]);
        end

        // R6: activations changed mid-sweep must not matter
        v = {8'd120, 8'd40, 8'd160, 8'd80};
        run_sweep(v, 1, "R6");
        check(widths[0] == 8, "R6 held activation n0", widths[0], 8);
        check(widths[1] == 12, "R6 held activation n1", widths[1], 12);

        // R7: start pulses during the sweep and done cycle are ignored
        run_sweep(v, 2, "R7");
        wait_idle_quiet(2);
        check(widths[3] == 10, "R7 width unchanged", widths[3], 10);

        // R9: new transfer function written while idle
        for (int i = 0; i < DEP; i++) begin
            write_entry(i, 100 + 4 * i);
            model_tbl[i] = 100 + 4 * i;
        end
        v = {8'd255, 8'd99, 8'd128, 8'd110};
        run_sweep(v, 0, "R9");
        check(widths[0] == 6, "R9 steep table n0", widths[0], 6);
        check(widths[1] == 16, "R9 steep table n1", widths[1], 16);
        check(widths[2] == 0, "R9 steep table n2", widths[2], 0);

        // R8: write to entry 0 during a sweep is dropped
        v = {8'd50, 8'd50, 8'd50, 8'd50};
        run_sweep(v, 3, "R8");
        run_sweep(v, 0, "R8 after");
        check(widths[0] == 0, "R8 busy write ignored", widths[0], 0);
        wait_idle_quiet(2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule